// File: doc/BRIEF.md
# Configurable Synchronous Serial Port

This block is one byte-wide synchronous serial transceiver channel. Software loads a byte into the shift register, writes a configuration word, and pulses `start`. The channel then clocks exactly eight bits out on the serial data output while it collects eight bits from the serial data input. When the byte is done it raises a one-cycle completion interrupt request, and the received byte can be read from `rd_data`.

The shift clock comes from one of two sources. As master, an on-chip divider makes it at one of six rates and drives it on the SCK pin. As slave, it takes an external SCK, passes it through a two-flop synchroniser and detects its edges. Bit order (MSB or LSB first) and wiring are chosen at run time. In 3-wire wiring the receive data comes from the SI pin. In 2-wire wiring it comes from the shared data line, read back through `sd_in`. Pads, pin multiplexing and the open-drain drivers sit outside. The channel only reports the requested open-drain setting on `od_en`.

Top module: `ssp_channel`

## Requirements
- R1: After reset `busy`=0, `irq`=0, `sck_out`=1, `sck_oe`=1, `so_oe`=0, `rd_data`=0 and `od_en`=0. The configuration resets to rate code 0, LSB first, 3-wire, internal clock, open drain off.
- R2: A `start` pulse while idle sets `busy` at that clock edge. A transfer moves exactly 8 bits. With the internal clock, `busy` falls D*8 clocks after the start edge, where D is the divider of the selected rate.
- R3: The configuration word is `cfg_wdata`: bits [2:0] rate code, bit 3 MSB-first, bit 4 two-wire, bit 5 external clock, bit 6 open drain. Rate codes 0..5 select dividers 360, 120, 24, 16, 12 and 10; codes 6 and 7 behave as code 5. The internal SCK idles high and spends D/2 clocks in each half period.
- R4: The first data bit is on `so_out` from the start edge. `so_out` changes only on SCK falling edges after the first. Receive data is sampled on SCK rising edges. `so_oe` is high exactly while busy.
- R5: With MSB-first set, bit 7 goes out first and the first received bit ends in bit 7. Otherwise bit 0 goes first and the first received bit ends in bit 0.
- R6: In two-wire mode the receive bits come from `sd_in` and `si_in` is ignored. In 3-wire mode they come from `si_in`.
- R7: In external clock mode `sck_oe`=0 and SCK edges act three clock edges after the pin changes. `busy` falls on the third clock edge after the eighth rising edge at `sck_in`.
- R8: `irq` is high for exactly one cycle, starting at the clock edge that clears `busy`.
- R9: While busy, data writes, configuration writes and `start` are ignored.
- R10: `od_en` follows configuration bit 6.
- R11: `rd_data` shows the shift register. After a data write it holds the written byte, and after a transfer it holds the received byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 7 | Configuration word |
| data_we | input | 1 | Shift data write strobe |
| data_wdata | input | 8 | Byte to transmit |
| start | input | 1 | Start a transfer |
| rd_data | output | 8 | Shift register contents |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Transfer-complete request, one cycle |
| sck_in | input | 1 | External SCK from the pad |
| sck_out | output | 1 | Internal SCK to the pad |
| sck_oe | output | 1 | SCK drive enable (master) |
| si_in | input | 1 | Serial input, 3-wire mode |
| sd_in | input | 1 | Shared data line readback, 2-wire mode |
| so_out | output | 1 | Serial data output |
| so_oe | output | 1 | Serial data drive enable |
| od_en | output | 1 | Open-drain request for the output pads |

## Verification
With the internal clock, every result is a function of the clock count n since the start edge. After n clocks SCK has toggled floor(n/(D/2)) times. `busy` and `irq` change at n = 8D. The bench's model recomputes the expected `sck_out`, `busy`, `so_out` and `irq` from n each cycle and compares at the falling clock edge, so every registered result has already settled. In external clock mode, effects trail the pin by three clock edges. The bench therefore checks that `busy` is still high two edges after the last rising edge on `sck_in` and has fallen, with `irq` high, one edge later. It drives receive data half an SCK period ahead of the sampling edge.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int unsigned CFG_W = 7;

  typedef struct packed {
    logic       od;
    logic       ext_clk;
    logic       two_wire;
    logic       msb_first;
    logic [2:0] rate;
  } ssp_cfg_t;
endpackage

// File: rtl/ssp_clkgen.sv
module ssp_clkgen #(
  parameter int unsigned CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] half,
  output logic          sck_q,
  output logic          fall_ev,
  output logic          rise_ev
);
  logic [CW-1:0] cnt;
  logic          tick;

  assign tick    = run && (cnt == half - 1'b1);
  assign fall_ev = tick && sck_q;
  assign rise_ev = tick && !sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      sck_q <= 1'b1;
    end else if (!run) begin
      cnt   <= '0;
      sck_q <= 1'b1;
    end else if (tick) begin
      cnt   <= '0;
      sck_q <= ~sck_q;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ssp_pin_sync.sv
module ssp_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall_ev,
  output logic rise_ev
);
  logic [STAGES:0] pipe;

  assign rise_ev = pipe[STAGES-1] && !pipe[STAGES];
  assign fall_ev = !pipe[STAGES-1] && pipe[STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '1;
    else        pipe <= {pipe[STAGES-1:0], pin};
  end
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_req,
  input  logic         load_we,
  input  logic [W-1:0] load_data,
  input  logic         fall_ev,
  input  logic         rise_ev,
  input  logic         rx_bit,
  input  logic         msb_first,
  output logic [W-1:0] shreg,
  output logic         tx_bit,
  output logic         busy,
  output logic         done_ev
);
  localparam int unsigned CNTW = (W > 2) ? $clog2(W) : 1;

  function automatic logic [W-1:0] next_word(logic [W-1:0] v, logic b, logic msb);
    return msb ? {v[W-2:0], b} : {b, v[W-1:1]};
  endfunction

  function automatic logic out_bit(logic [W-1:0] v, logic msb);
    return msb ? v[W-1] : v[0];
  endfunction

  logic [CNTW-1:0] rise_cnt;
  logic            seen_fall;
  logic            samp;

  assign tx_bit  = out_bit(shreg, msb_first);
  assign done_ev = busy && rise_ev && (rise_cnt == CNTW'(W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '0;
      busy      <= 1'b0;
      rise_cnt  <= '0;
      seen_fall <= 1'b0;
      samp      <= 1'b0;
    end else if (!busy) begin
      if (load_we) shreg <= load_data;
      if (start_req) begin
        busy      <= 1'b1;
        rise_cnt  <= '0;
        seen_fall <= 1'b0;
      end
    end else if (rise_ev) begin
      samp     <= rx_bit;
      rise_cnt <= rise_cnt + 1'b1;
      if (done_ev) begin
        shreg <= next_word(shreg, rx_bit, msb_first);
        busy  <= 1'b0;
      end
    end else if (fall_ev) begin
      if (seen_fall) shreg <= next_word(shreg, samp, msb_first);
      seen_fall <= 1'b1;
    end
  end
endmodule

// File: rtl/ssp_channel.sv
module ssp_channel
  import ssp_pkg::*;
#(
  parameter int unsigned W      = 8,
  parameter int unsigned DIV_R0 = 360,
  parameter int unsigned DIV_R1 = 120,
  parameter int unsigned DIV_R2 = 24,
  parameter int unsigned DIV_R3 = 16,
  parameter int unsigned DIV_R4 = 12,
  parameter int unsigned DIV_R5 = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             data_we,
  input  logic [W-1:0]     data_wdata,
  input  logic             start,
  output logic [W-1:0]     rd_data,
  output logic             busy,
  output logic             irq,
  input  logic             sck_in,
  output logic             sck_out,
  output logic             sck_oe,
  input  logic             si_in,
  input  logic             sd_in,
  output logic             so_out,
  output logic             so_oe,
  output logic             od_en
);
  localparam int unsigned CW = $clog2(DIV_R0 + 1);

  function automatic logic [CW-1:0] half_of(logic [2:0] code);
    case (code)
      3'd0:    return CW'(DIV_R0 / 2);
      3'd1:    return CW'(DIV_R1 / 2);
      3'd2:    return CW'(DIV_R2 / 2);
      3'd3:    return CW'(DIV_R3 / 2);
      3'd4:    return CW'(DIV_R4 / 2);
      default: return CW'(DIV_R5 / 2);
    endcase
  endfunction

  ssp_cfg_t      cfg_q;
  logic [CW-1:0] half;
  logic          gen_fall, gen_rise, ext_fall, ext_rise;
  logic          shift_fall, shift_rise, done_ev, rx_bit, sck_q;

  assign half = half_of(cfg_q.rate);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      irq   <= 1'b0;
    end else begin
      if (cfg_we && !busy) cfg_q <= ssp_cfg_t'(cfg_wdata);
      irq <= done_ev;
    end
  end

  ssp_clkgen #(.CW(CW)) u_gen (
    .clk(clk), .rst_n(rst_n), .run(busy && !cfg_q.ext_clk), .half(half),
    .sck_q(sck_q), .fall_ev(gen_fall), .rise_ev(gen_rise)
  );

  ssp_pin_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(sck_in),
    .fall_ev(ext_fall), .rise_ev(ext_rise)
  );

  assign shift_fall = cfg_q.ext_clk ? ext_fall : gen_fall;
  assign shift_rise = cfg_q.ext_clk ? ext_rise : gen_rise;
  assign rx_bit     = cfg_q.two_wire ? sd_in : si_in;

  ssp_shifter #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start_req(start), .load_we(data_we),
    .load_data(data_wdata), .fall_ev(shift_fall), .rise_ev(shift_rise),
    .rx_bit(rx_bit), .msb_first(cfg_q.msb_first), .shreg(rd_data),
    .tx_bit(so_out), .busy(busy), .done_ev(done_ev)
  );

  assign sck_out = sck_q;
  assign sck_oe  = !cfg_q.ext_clk;
  assign so_oe   = busy;
  assign od_en   = cfg_q.od;
endmodule

// File: rtl/ssp_channel_chk.sv
module ssp_channel_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic irq,
  input logic sck_out,
  input logic sck_oe,
  input logic so_out,
  input logic od_en,
  input logic shift_fall,
  input logic shift_rise,
  input logic done_ev
);
  a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  a_r8_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r8_irq_at_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(busy) && !busy));

  a_r3_sck_idles_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && sck_oe) |-> sck_out);

  a_r4_so_holds_between_falls: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !shift_fall && !done_ev) |=> $stable(so_out));

  a_r4_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({shift_fall, shift_rise}));

  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(od_en));
endmodule

bind ssp_channel ssp_channel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .irq(irq),
  .sck_out(sck_out), .sck_oe(sck_oe), .so_out(so_out), .od_en(od_en),
  .shift_fall(shift_fall), .shift_rise(shift_rise), .done_ev(done_ev)
);

// File: tb/sim_ssp_channel.sv
`timescale 1ns/1ps
module sim_ssp_channel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [6:0] cfg_wdata = '0;
  logic       data_we = 1'b0;
  logic [7:0] data_wdata = '0;
  logic       start = 1'b0;
  logic [7:0] rd_data;
  logic       busy, irq, sck_out, sck_oe, so_out, so_oe, od_en;
  logic       sck_in = 1'b1;
  logic       si_in = 1'b1;
  logic       sd_in = 1'b1;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  ssp_channel u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .data_we(data_we), .data_wdata(data_wdata), .start(start),
    .rd_data(rd_data), .busy(busy), .irq(irq), .sck_in(sck_in),
    .sck_out(sck_out), .sck_oe(sck_oe), .si_in(si_in), .sd_in(sd_in),
    .so_out(so_out), .so_oe(so_oe), .od_en(od_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int half_for(input int code);
    case (code)
      0: return 180;
      1: return 60;
      2: return 12;
      3: return 8;
      4: return 6;
      default: return 5;
    endcase
  endfunction

  function automatic int pos(input bit msb, input int k);
    return msb ? 7 - k : k;
  endfunction

  task automatic write_cfg(input bit od, ext, two, msb, input int code);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = {od, ext, two, msb, 3'(code)};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load(input logic [7:0] b);
    data_we = 1'b1;
    data_wdata = b;
    @(negedge clk);
    data_we = 1'b0;
    chk("R11 load", rd_data, b);
  endtask

  // receive line driven with the wanted bit, the other line with its inverse
  task automatic drive_rx(input bit two, input bit v);
    if (two) begin sd_in = v; si_in = ~v; end
    else     begin si_in = v; sd_in = ~v; end
  endtask

  task automatic run_int(input int code, input bit msb, two,
                         input logic [7:0] tx, rx, input bit poke);
    int h;
    int lim;
    h = half_for(code);
    lim = 16 * h;
    write_cfg(1'b0, 1'b0, two, msb, code);
    load(tx);
    drive_rx(two, rx[pos(msb, 0)]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n <= lim + 2; n++) begin
      int t;
      int falls;
      int s;
      t = n / h;
      if (t > 16) t = 16;
      falls = (t + 1) / 2;
      s = (falls > 0) ? falls - 1 : 0;
      if (s > 7) s = 7;
      chk("R2 busy", busy, (t < 16));
      chk("R3 sck_out", sck_out, (t % 2 == 0));
      chk("R4 so_oe", so_oe, (t < 16));
      chk("R8 irq", irq, (n == lim));
      if (t < 16) chk(msb ? "R5 so_out msb" : "R4 so_out", so_out, tx[pos(msb, s)]);
      drive_rx(two, rx[pos(msb, s)]);
      if (poke && n == 5) begin
        data_we = 1'b1; data_wdata = ~rx;
        cfg_we = 1'b1; cfg_wdata = {1'b1, 1'b0, ~two, ~msb, 3'd0};
        start = 1'b1;
      end
      if (n == 6) begin
        data_we = 1'b0; cfg_we = 1'b0; start = 1'b0;
      end
      @(negedge clk);
    end
    chk(two ? "R6 rx two-wire" : "R11 rx byte", rd_data, rx);
    if (poke) begin
      chk("R9 cfg write ignored", od_en, 0);
      chk("R9 start ignored", busy, 0);
    end
  endtask

  task automatic run_ext(input bit msb, input logic [7:0] tx, rx);
    write_cfg(1'b0, 1'b1, 1'b0, msb, 0);
    load(tx);
    chk("R7 sck_oe", sck_oe, 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 8; k++) begin
      sck_in = 1'b0;
      drive_rx(1'b0, rx[pos(msb, k)]);
      repeat (6) @(negedge clk);
      chk("R7 so_out ext", so_out, tx[pos(msb, k)]);
      chk("R7 busy ext", busy, 1);
      sck_in = 1'b1;
      if (k < 7) repeat (6) @(negedge clk);
    end
    @(negedge clk);
    @(negedge clk);
    chk("R7 busy two edges after", busy, 1);
    @(negedge clk);
    chk("R7 busy third edge", busy, 0);
    chk("R8 irq ext", irq, 1);
    @(negedge clk);
    chk("R8 irq single", irq, 0);
    chk("R7 rx ext", rd_data, rx);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 irq", irq, 0);
    chk("R1 sck_out", sck_out, 1);
    chk("R1 sck_oe", sck_oe, 1);
    chk("R1 so_oe", so_oe, 0);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 od_en", od_en, 0);

    run_int(0, 1'b1, 1'b0, 8'hA5, 8'h3C, 1'b0);
    run_int(5, 1'b0, 1'b0, 8'h81, 8'hC6, 1'b1);
    run_int(3, 1'b1, 1'b1, 8'h5A, 8'h97, 1'b0);
    run_int(7, 1'b0, 1'b1, 8'h2E, 8'h71, 1'b0);
    run_int(2, 1'b0, 1'b0, 8'hF0, 8'h0D, 1'b0);

    write_cfg(1'b1, 1'b0, 1'b0, 1'b0, 4);
    chk("R10 od_en set", od_en, 1);
    write_cfg(1'b0, 1'b0, 1'b0, 1'b0, 4);
    chk("R10 od_en clear", od_en, 0);

    run_ext(1'b1, 8'hC3, 8'h6B);
    run_ext(1'b0, 8'h1E, 8'hB4);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule